// File: doc/BRIEF.md
# Four-Channel PWM Timer with Shadowed Reload and Compare

The block generates four pulse-width-modulated outputs from one shared time base. A prescaler divides the input clock, and the divided ticks step a single up-counter that returns to zero after it reaches a programmable limit. Every channel compares the shared count against its own threshold. The channel's raw level is active while the count is below the threshold. From that level the channel drives a main output and an inverted companion output. Each of the two outputs has its own enable bit and its own inversion bit.

Software programs the block through a simple one-cycle write port. The prescaler value and the channel thresholds are written to holding registers. They move into the working registers only on an update event. An update event is either the counter wrapping from the limit to zero or a forced update written by software. The limit can be held back the same way, or it can take effect on the write, as selected by a control bit. A global output gate forces all eight outputs low while it is clear.

Top module: `pwm_timer`

## Requirements
- R1: After reset the count is 0, the update pulse is low, and every main and companion output is low.
- R2: While running, the count steps once every prescaler+1 clocks. It returns to 0 on the step after it equals the limit, so one period lasts (prescaler+1)*(limit+1) clocks. Prescaler is written at address 2 and limit at address 3.
- R3: `upd_o` is high for exactly the one cycle after an update event is applied, and the count is 0 in that cycle.
- R4: Control register address 0, bit 1 selects how a limit write takes effect. When it is set, a new limit is held until the next update event. When it is clear, the new limit acts from the cycle after the write.
- R5: Prescaler and threshold writes (threshold of channel c at address 5+c) affect the outputs only after the next update event. A write that lands on the same clock edge as a wrap waits for the update after that one.
- R6: Writing data bit 0 = 1 to address 1 forces an update event, whether or not the counter runs. The event loads every held value and clears the count and prescaler phase.
- R7: A channel's raw level is active when the count is below its threshold. Threshold 0 keeps it inactive, and a threshold above the limit keeps it active.
- R8: The channel word at address 4 holds one nibble per channel: bits 4c+0 main enable, 4c+1 main invert, 4c+2 companion enable, 4c+3 companion invert. An enabled main output equals raw level XOR invert. An enabled companion equals NOT raw level XOR its invert. A disabled output is low.
- R9: Control bit 2 gates all outputs. While it is clear, every main and companion output is low and the counter keeps running.
- R10: Control bit 0 runs the counter. While it is clear, the count and prescaler phase hold and no wrap event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | DATA_W (16) | Write data |
| cnt_o | output | CNT_W (16) | Current count |
| upd_o | output | 1 | Update event applied in the previous cycle |
| pwm_o | output | N_CH (4) | Main channel outputs |
| pwm_n_o | output | N_CH (4) | Companion channel outputs |

## Verification
A software write to a threshold holding register can fall on the same clock edge as a natural wrap of the counter. At that edge the working register loads from the holding register. The bench provokes this by counting clocks from a forced update, so that the threshold write is clocked on exactly the edge where the count goes from the limit to 0. It then judges the result over the next two full periods. The first period must still show the old duty and the second must show the new one, which shows that the held value was sampled before the write.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_FORCE = 4'd1;
  localparam logic [ADDR_W-1:0] A_DIV   = 4'd2;
  localparam logic [ADDR_W-1:0] A_LIMIT = 4'd3;
  localparam logic [ADDR_W-1:0] A_CHAN  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMP0  = 4'd5;

  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_BUF = 1;
  localparam int unsigned CTRL_OE  = 2;

  localparam int unsigned CFG_W = 4;

  // bit order matches the per-channel nibble: en at bit 0
  typedef struct packed {
    logic npol;
    logic nen;
    logic pol;
    logic en;
  } chan_cfg_t;

endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  input  logic                           wrap_i,
  output logic                           run_o,
  output logic                           out_en_o,
  output logic                           force_o,
  output logic [PSC_W-1:0]               psc_o,
  output logic [CNT_W-1:0]               arr_o,
  output logic [N_CH-1:0][CNT_W-1:0]     cmp_o,
  output chan_cfg_t [N_CH-1:0]           cfg_o
);

  localparam int unsigned CFG_BITS = CFG_W * N_CH;

  logic                run_q, buf_q, oe_q;
  logic [PSC_W-1:0]    psc_pre_q, psc_act_q;
  logic [CNT_W-1:0]    arr_pre_q, arr_act_q;
  logic [CFG_BITS-1:0] cfg_q;
  logic                upd;

  assign force_o = wr_en_i && (wr_addr_i == A_FORCE) && wr_data_i[0];
  assign upd     = wrap_i || force_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      buf_q <= 1'b0;
      oe_q  <= 1'b0;
      cfg_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_CTRL) begin
        run_q <= wr_data_i[CTRL_RUN];
        buf_q <= wr_data_i[CTRL_BUF];
        oe_q  <= wr_data_i[CTRL_OE];
      end
      if (wr_addr_i == A_CHAN) cfg_q <= wr_data_i[CFG_BITS-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_pre_q <= '0;
      psc_act_q <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == A_DIV) psc_pre_q <= wr_data_i[PSC_W-1:0];
      if (upd) psc_act_q <= psc_pre_q;
    end
  end

  // unbuffered limit write bypasses the update event and wins over it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_pre_q <= '0;
      arr_act_q <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == A_LIMIT) arr_pre_q <= wr_data_i[CNT_W-1:0];
      if (wr_en_i && wr_addr_i == A_LIMIT && !buf_q) arr_act_q <= wr_data_i[CNT_W-1:0];
      else if (upd) arr_act_q <= arr_pre_q;
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_cmp
    localparam logic [ADDR_W-1:0] CMP_ADDR = ADDR_W'(int'(A_CMP0) + c);
    logic [CNT_W-1:0] pre_q, act_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pre_q <= '0;
        act_q <= '0;
      end else begin
        if (wr_en_i && wr_addr_i == CMP_ADDR) pre_q <= wr_data_i[CNT_W-1:0];
        if (upd) act_q <= pre_q;
      end
    end

    assign cmp_o[c] = act_q;
    assign cfg_o[c] = chan_cfg_t'(cfg_q[CFG_W*c +: CFG_W]);
  end

  assign run_o    = run_q;
  assign out_en_o = oe_q;
  assign psc_o    = psc_act_q;
  assign arr_o    = arr_act_q;

endmodule

// File: rtl/pwm_timer_base.sv
module pwm_timer_base #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             force_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             upd_o
);

  logic [PSC_W-1:0] pc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             upd_q;
  logic             tick;

  assign tick   = (pc_q == psc_i);
  assign wrap_o = run_i && tick && (cnt_q == arr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= wrap_o || force_i;
      if (force_i) begin
        pc_q  <= '0;
        cnt_q <= '0;
      end else if (run_i) begin
        if (tick) begin
          pc_q  <= '0;
          cnt_q <= (cnt_q == arr_i) ? '0 : cnt_q + 1'b1;
        end else begin
          pc_q <= pc_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign upd_o = upd_q;

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  chan_cfg_t        cfg_i,
  input  logic             out_en_i,
  output logic             pwm_o,
  output logic             pwm_n_o
);

  logic lvl;

  assign lvl     = (cnt_i < cmp_i);
  assign pwm_o   = out_en_i && cfg_i.en  && (lvl ^ cfg_i.pol);
  assign pwm_n_o = out_en_i && cfg_i.nen && (!lvl ^ cfg_i.npol);

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              upd_o,
  output logic [N_CH-1:0]   pwm_o,
  output logic [N_CH-1:0]   pwm_n_o
);

  logic                       run, out_en, force_upd, wrap;
  logic [PSC_W-1:0]           psc_act;
  logic [CNT_W-1:0]           arr_act;
  logic [N_CH-1:0][CNT_W-1:0] cmp_act;
  chan_cfg_t [N_CH-1:0]       chan_cfg;

  pwm_timer_regs #(
    .N_CH(N_CH), .CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .wrap_i   (wrap),
    .run_o    (run),
    .out_en_o (out_en),
    .force_o  (force_upd),
    .psc_o    (psc_act),
    .arr_o    (arr_act),
    .cmp_o    (cmp_act),
    .cfg_o    (chan_cfg)
  );

  pwm_timer_base #(
    .CNT_W(CNT_W), .PSC_W(PSC_W)
  ) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .force_i(force_upd),
    .psc_i  (psc_act),
    .arr_i  (arr_act),
    .cnt_o  (cnt_o),
    .wrap_o (wrap),
    .upd_o  (upd_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pwm_timer_chan #(
      .CNT_W(CNT_W)
    ) u_chan (
      .cnt_i   (cnt_o),
      .cmp_i   (cmp_act[c]),
      .cfg_i   (chan_cfg[c]),
      .out_en_i(out_en),
      .pwm_o   (pwm_o[c]),
      .pwm_n_o (pwm_n_o[c])
    );
  end

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwm_timer_pkg::*;
#(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned CNT_W = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       run_i,
  input logic                       force_i,
  input logic                       oe_i,
  input logic                       upd_i,
  input logic [CNT_W-1:0]           cnt_i,
  input logic [N_CH-1:0]            pwm_i,
  input logic [N_CH-1:0]            pwm_n_i,
  input chan_cfg_t [N_CH-1:0]       cfg_i,
  input logic [N_CH-1:0][CNT_W-1:0] cmp_i
);

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_i) |-> (cnt_i == $past(cnt_i) + CNT_W'(1)) || (cnt_i == '0));

  // R3
  upd_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> (cnt_i == '0));

  // R6
  force_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> (cnt_i == '0) && upd_i);

  // R9
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (pwm_i == '0) && (pwm_n_i == '0));

  // R10
  hold_when_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !force_i) |=> $stable(cnt_i) && !upd_i);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    // R7
    zero_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oe_i && cfg_i[c].en && !cfg_i[c].pol && cmp_i[c] == '0) |-> !pwm_i[c]);

    // R8
    comp_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_i[c].nen |-> !pwm_n_i[c]);
  end

endmodule

bind pwm_timer pwm_timer_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .run_i  (run),
  .force_i(force_upd),
  .oe_i   (out_en),
  .upd_i  (upd_o),
  .cnt_i  (cnt_o),
  .pwm_i  (pwm_o),
  .pwm_n_i(pwm_n_o),
  .cfg_i  (chan_cfg),
  .cmp_i  (cmp_act)
);

// File: tb/tb_pwm_timer.sv
module tb_pwm_timer;

  localparam int CLK_PERIOD = 10;
  localparam int N_CH = 4;
  localparam int CNT_W = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [3:0]        wr_addr_i = '0;
  logic [15:0]       wr_data_i = '0;
  logic [CNT_W-1:0]  cnt_o;
  logic              upd_o;
  logic [N_CH-1:0]   pwm_o, pwm_n_o;

  int n_tests = 0;
  int n_fail  = 0;

  pwm_timer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cnt_o(cnt_o), .upd_o(upd_o), .pwm_o(pwm_o), .pwm_n_o(pwm_n_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    #1;
    wr_en_i = 1'b0;
  endtask

  // program everything, then force an update; next negedge is sample k=0
  task automatic setup(input int psc, input int lim, input int cmp,
                       input logic [15:0] chw, input logic [15:0] ctrl);
    wr(4'd2, 16'(psc));
    wr(4'd3, 16'(lim));
    for (int c = 0; c < N_CH; c++) wr(4'(5 + c), 16'(cmp));
    wr(4'd4, chw);
    wr(4'd0, ctrl);
    wr(4'd1, 16'd1);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check(cnt_o == 0 && upd_o == 0, "R1 count/update", int'(cnt_o), 0);
    check(pwm_o == 0 && pwm_n_o == 0, "R1 outputs", int'({pwm_o, pwm_n_o}), 0);
  endtask

  task automatic t_basic();
    int e_cnt = 0, e_pwm = 0, e_upd = 0;
    setup(0, 9, 3, 16'h0001, 16'h0005);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      if (cnt_o != CNT_W'(k % 10)) e_cnt++;
      if (pwm_o[0] != ((k % 10) < 3)) e_pwm++;
      if (upd_o != ((k % 10) == 0)) e_upd++;
    end
    check(e_cnt == 0, "R2 count sequence", e_cnt, 0);
    check(e_pwm == 0, "R7 duty 3 of 10", e_pwm, 0);
    check(e_upd == 0, "R3 update pulse", e_upd, 0);
  endtask

  task automatic t_prescale();
    int err = 0;
    setup(2, 4, 2, 16'h0001, 16'h0005);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk_i);
      if (cnt_o != CNT_W'((k / 3) % 5)) err++;
      if (pwm_o[0] != (((k / 3) % 5) < 2)) err++;
    end
    check(err == 0, "R2 prescaler 3, period 15", err, 0);
  endtask

  task automatic t_limit_buffered();
    int err = 0;
    setup(0, 9, 3, 16'h0001, 16'h0007);
    wr(4'd3, 16'd4);
    for (int k = 1; k < 20; k++) begin
      @(negedge clk_i);
      if (cnt_o != CNT_W'((k < 10) ? k : (k - 10) % 5)) err++;
    end
    check(err == 0, "R4 buffered limit deferred", err, 0);
  endtask

  task automatic t_limit_direct();
    int err = 0;
    setup(0, 9, 3, 16'h0001, 16'h0005);
    wr(4'd3, 16'd4);
    for (int k = 1; k < 15; k++) begin
      @(negedge clk_i);
      if (cnt_o != CNT_W'(k % 5)) err++;
    end
    check(err == 0, "R4 direct limit immediate", err, 0);
  endtask

  task automatic t_cmp_preload();
    int err = 0;
    setup(0, 9, 3, 16'h0001, 16'h0005);
    wr(4'd5, 16'd7);
    for (int k = 1; k < 20; k++) begin
      @(negedge clk_i);
      if (pwm_o[0] != ((k % 10) < ((k < 10) ? 3 : 7))) err++;
    end
    check(err == 0, "R5 threshold waits for wrap", err, 0);
  endtask

  task automatic t_psc_preload();
    int err = 0;
    setup(0, 4, 2, 16'h0001, 16'h0005);
    wr(4'd2, 16'd1);
    for (int k = 1; k < 25; k++) begin
      @(negedge clk_i);
      if (cnt_o != CNT_W'((k < 5) ? k : ((k - 5) / 2) % 5)) err++;
    end
    check(err == 0, "R5 prescaler waits for wrap", err, 0);
  endtask

  task automatic t_collision();
    int err = 0;
    setup(0, 9, 3, 16'h0001, 16'h0005);
    repeat (9) @(negedge clk_i);
    wr(4'd5, 16'd7);  // clocked on the wrap edge
    for (int k = 10; k < 30; k++) begin
      @(negedge clk_i);
      if (pwm_o[0] != ((k % 10) < ((k < 20) ? 3 : 7))) err++;
    end
    check(err == 0, "R5 write on wrap edge", err, 0);
  endtask

  task automatic t_force();
    int err = 0;
    setup(0, 9, 0, 16'h0001, 16'h0004);
    @(negedge clk_i);
    check(pwm_o[0] == 0 && cnt_o == 0, "R6 stopped after force", int'(pwm_o[0]), 0);
    wr(4'd5, 16'd5);
    @(negedge clk_i);
    check(pwm_o[0] == 0, "R5 stopped, no update yet", int'(pwm_o[0]), 0);
    wr(4'd1, 16'd1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      if (pwm_o[0] != 1'b1 || cnt_o != 0) err++;
    end
    check(err == 0, "R6 force loads while stopped", err, 0);
    setup(0, 9, 3, 16'h0001, 16'h0005);
    repeat (5) @(negedge clk_i);
    wr(4'd1, 16'd1);
    @(negedge clk_i);
    check(cnt_o == 0 && upd_o == 1, "R6 force clears running count", int'(cnt_o), 0);
  endtask

  task automatic t_edges();
    int e0 = 0, e1 = 0, e2 = 0;
    setup(0, 9, 0, 16'h0001, 16'h0005);
    for (int k = 0; k < 20; k++) begin @(negedge clk_i); if (pwm_o[0]) e0++; end
    check(e0 == 0, "R7 threshold 0 never active", e0, 0);
    setup(0, 9, 10, 16'h0001, 16'h0005);
    for (int k = 0; k < 20; k++) begin @(negedge clk_i); if (!pwm_o[0]) e1++; end
    check(e1 == 0, "R7 threshold above limit always active", e1, 0);
    setup(0, 9, 9, 16'h0001, 16'h0005);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      if (pwm_o[0] != ((k % 10) != 9)) e2++;
    end
    check(e2 == 0, "R7 threshold equal to limit", e2, 0);
  endtask

  task automatic t_polarity();
    int err = 0;
    logic r;
    // ch0 en+cen, ch1 en+inv+cen, ch2 en+cen+cinv, ch3 en only
    setup(0, 9, 3, 16'h1D75, 16'h0005);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      r = ((k % 10) < 3);
      if (pwm_o   != {r, r, !r, r})      err++;
      if (pwm_n_o != {1'b0, r, !r, !r})  err++;
    end
    check(err == 0, "R8 enables and inversions", err, 0);
  endtask

  task automatic t_gate();
    int err = 0;
    int moved = 0;
    setup(0, 9, 3, 16'h1D75, 16'h0001);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      if (pwm_o != 0 || pwm_n_o != 0) err++;
      if (cnt_o != 0) moved++;
    end
    check(err == 0, "R9 gate clear forces low", err, 0);
    check(moved == 18, "R9 counter runs while gated", moved, 18);
  endtask

  task automatic t_stop();
    int err = 0;
    logic [CNT_W-1:0] held;
    setup(0, 9, 3, 16'h0001, 16'h0005);
    repeat (3) @(negedge clk_i);
    wr(4'd0, 16'h0004);
    @(negedge clk_i);
    held = cnt_o;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk_i);
      if (cnt_o != held || upd_o) err++;
    end
    check(err == 0, "R10 count holds when stopped", err, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_prescale();
    t_limit_buffered();
    t_limit_direct();
    t_cmp_preload();
    t_psc_preload();
    t_collision();
    t_force();
    t_edges();
    t_polarity();
    t_gate();
    t_stop();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule